// File: doc/BRIEF.md
# Byte-Synchronous Receiver with Delayed CRC Check

The receiver takes a serial bit stream, qualified by a one-cycle bit-time enable, and first searches it for a programmable 8-bit sync pattern. After the pattern is found, it cuts the stream into 8-bit characters and stores each one in a small receive FIFO. Each stored character has a status entry next to it. The status entry holds the current CRC check result and an overrun marker.

Assembled characters do not go straight into the CRC. They wait in an 8-bit holding stage first, and only then are shifted through a CRC-16 checker with polynomial x^16+x^12+x^5+1. The host reads a character and then sets the CRC enable. The enable is sampled at the next character boundary, and it decides whether that same character is fed into the CRC. This lets the host leave out a character after seeing its value. The consequence is that the check result covering a character arrives in the status of the character two places later.

Top module: `bsync_rx`

## Requirements
- R1: After reset and after every hunt command, `inHunt` is 1 and nothing is written to the FIFO. While hunting, the value formed by shifting the current bit into the shift register is compared with `syncChar` on every bit time. A match clears `inHunt`.
- R2: The matching sync character itself is never stored. The FIFO stays empty until eight further bit times have been received.
- R3: Once synchronised, one character is moved into the FIFO every eight bit times. Bits arrive MSB first, so the first bit received after a boundary becomes bit 7 of the character.
- R4: `crcEnable` is sampled only at character boundaries. The value held between the transfer of character N and the transfer of character N+1 decides whether character N is shifted into the CRC.
- R5: The status stored with character K reflects the CRC state after all included characters up to and including K-2. The status is not affected by characters K-1 or K.
- R6: The CRC is CRC-16 with polynomial 0x1021, processed MSB first. Its preset is 0xFFFF when `crcPresetOnes`=1 and 0x0000 when it is 0. `rdCrcErr` is 1 when the remainder is non-zero, so a frame followed by its own CRC bytes (high byte first) reads 0.
- R7: A `huntCmd` pulse puts the receiver into hunt. It also clears the sampled enable, the holding stage and the CRC state. The CRC is loaded with the preset when sync is found again.
- R8: If a transfer finds the FIFO full and no read happens in the same cycle, the character is dropped. The next character that is stored carries `rdOverrun`=1, and later characters carry 0.
- R9: A transfer that falls in the same cycle as a read of a full FIFO is stored and is not treated as an overrun.
- R10: The FIFO returns characters in arrival order, together with their status entries. It holds `DEPTH` entries (3 by default, 8 also supported). `dataValid` is 1 exactly when it is non-empty, and `rdEn` removes the head entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle strobe marking a valid bit time |
| rxBit | input | 1 | Serial data, sampled when bitEn is 1 |
| syncChar | input | 8 | Sync pattern searched while hunting |
| crcPresetOnes | input | 1 | 1: CRC preset 0xFFFF, 0: preset 0x0000 |
| crcEnable | input | 1 | Host CRC include request, sampled at boundaries |
| huntCmd | input | 1 | Pulse to re-enter hunt and reset the CRC |
| rdEn | input | 1 | Pop the FIFO head |
| inHunt | output | 1 | Receiver is searching for sync |
| dataValid | output | 1 | FIFO holds at least one character |
| rdData | output | 8 | Character at the FIFO head |
| rdCrcErr | output | 1 | CRC non-zero flag paired with the head character |
| rdOverrun | output | 1 | Drop marker paired with the head character |

## Verification
A character transfer and a host read can fall in the same clock cycle. This matters most when the FIFO is already full, because in that case the push may go ahead only because of the pop. The bench first fills the FIFO with reads held off. It then releases the reader exactly on the bit time that completes the next character, so the pop and the push share one edge. The bench expects that character to appear afterwards with no overrun marker. A separate run, with the reader kept off, must show the drops and the marker on the following stored character.

// File: rtl/bsync_rx_pkg.sv
package bsync_rx_pkg;

  localparam int CHAR_W = 8;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;      // a bit time occurs
    logic xfer;       // character boundary
    logic huntEnter;  // hunt command
    logic huntExit;   // sync found
  } ctrlStb_t;

  typedef struct packed {
    logic ovr;
    logic crcErr;
  } rxStat_t;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    logic [CRC_W-1:0] n;
    fb = c[CRC_W-1] ^ b;
    n  = {c[CRC_W-2:0], 1'b0};
    if (fb) n = n ^ CRC_POLY;
    return n;
  endfunction

endpackage

// File: rtl/bsync_rx_ctrl.sv
module bsync_rx_ctrl
  import bsync_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitEn,
  input  logic     huntCmd,
  input  logic     syncHit,
  output ctrlStb_t stb,
  output logic     inHunt
);

  localparam int CNT_W = $clog2(CHAR_W);

  logic             hunting;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hunting <= 1'b1;
      bitCnt  <= '0;
    end else if (huntCmd) begin
      hunting <= 1'b1;
      bitCnt  <= '0;
    end else if (bitEn) begin
      if (hunting) begin
        if (syncHit) hunting <= 1'b0;
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.shift     = bitEn;
    stb.huntEnter = huntCmd;
    stb.huntExit  = hunting && bitEn && syncHit && !huntCmd;
    stb.xfer      = !hunting && bitEn && !huntCmd && (bitCnt == CNT_W'(CHAR_W - 1));
  end

  assign inHunt = hunting;

endmodule

// File: rtl/bsync_rx_dp.sv
module bsync_rx_dp
  import bsync_rx_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStb_t                      stb,
  input  logic                          rxBit,
  input  logic [CHAR_W-1:0]             syncChar,
  input  logic                          crcPresetOnes,
  input  logic                          crcEnable,
  input  logic                          rdEn,
  output logic                          syncHit,
  output logic                          dataValid,
  output logic [CHAR_W-1:0]             rdData,
  output logic                          rdCrcErr,
  output logic                          rdOverrun,
  output logic [$clog2(DEPTH+1)-1:0]    fifoCount
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [CHAR_W-1:0] shReg, shNext, holdReg, crcSh;
  logic              crcEnLat;
  logic [CRC_W-1:0]  crcReg, crcNow, crcPreset;

  assign shNext    = {shReg[CHAR_W-2:0], rxBit};
  assign syncHit   = (shNext == syncChar);
  assign crcPreset = crcPresetOnes ? '1 : '0;
  assign crcNow    = (stb.shift && crcEnLat) ? crcStep(crcReg, crcSh[CHAR_W-1]) : crcReg;

  // shift register, holding stage, CRC feed
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      holdReg  <= '0;
      crcSh    <= '0;
      crcEnLat <= 1'b0;
      crcReg   <= '1;
    end else if (stb.huntEnter) begin
      holdReg  <= '0;
      crcSh    <= '0;
      crcEnLat <= 1'b0;
      crcReg   <= crcPreset;
    end else begin
      if (stb.shift) shReg <= shNext;
      if (stb.huntExit) begin
        crcReg <= crcPreset;
      end else begin
        crcReg <= crcNow;
      end
      if (stb.xfer) begin
        holdReg  <= shNext;
        crcSh    <= holdReg;
        crcEnLat <= crcEnable;
      end else if (stb.shift) begin
        crcSh <= {crcSh[CHAR_W-2:0], 1'b0};
      end
    end
  end

  // paired data and status FIFO
  logic [CHAR_W-1:0] dataMem [DEPTH];
  rxStat_t           statMem [DEPTH];
  logic [PW-1:0]     wrPtr, rdPtr, wrPtrNx, rdPtrNx;
  logic [CW-1:0]     count;
  logic              full, doPop, doPush, drop, ovrSticky;
  rxStat_t           statIn;

  assign full   = (count == CW'(DEPTH));
  assign doPop  = rdEn && (count != '0);
  assign doPush = stb.xfer && (!full || doPop);
  assign drop   = stb.xfer && full && !doPop;

  assign statIn.crcErr = (crcNow != '0);
  assign statIn.ovr    = ovrSticky;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wrPtrNx = wrPtr + 1'b1;
      assign rdPtrNx = rdPtr + 1'b1;
    end else begin : g_wrap
      assign wrPtrNx = (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      assign rdPtrNx = (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (doPush) begin
      dataMem[wrPtr] <= shNext;
      statMem[wrPtr] <= statIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      ovrSticky <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtrNx;
      if (doPop)  rdPtr <= rdPtrNx;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (drop)        ovrSticky <= 1'b1;
      else if (doPush) ovrSticky <= 1'b0;
    end
  end

  assign dataValid = (count != '0);
  assign rdData    = dataMem[rdPtr];
  assign rdCrcErr  = statMem[rdPtr].crcErr;
  assign rdOverrun = statMem[rdPtr].ovr;
  assign fifoCount = count;

endmodule

// File: rtl/bsync_rx.sv
module bsync_rx
  import bsync_rx_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       rxBit,
  input  logic [7:0] syncChar,
  input  logic       crcPresetOnes,
  input  logic       crcEnable,
  input  logic       huntCmd,
  input  logic       rdEn,
  output logic       inHunt,
  output logic       dataValid,
  output logic [7:0] rdData,
  output logic       rdCrcErr,
  output logic       rdOverrun
);

  ctrlStb_t                   stb;
  logic                       syncHit;
  logic                       xfer;
  logic [$clog2(DEPTH+1)-1:0] fifoCount;

  assign xfer = stb.xfer;

  bsync_rx_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitEn   (bitEn),
    .huntCmd (huntCmd),
    .syncHit (syncHit),
    .stb     (stb),
    .inHunt  (inHunt)
  );

  bsync_rx_dp #(.DEPTH(DEPTH)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .rxBit         (rxBit),
    .syncChar      (syncChar),
    .crcPresetOnes (crcPresetOnes),
    .crcEnable     (crcEnable),
    .rdEn          (rdEn),
    .syncHit       (syncHit),
    .dataValid     (dataValid),
    .rdData        (rdData),
    .rdCrcErr      (rdCrcErr),
    .rdOverrun     (rdOverrun),
    .fifoCount     (fifoCount)
  );

endmodule

// File: rtl/bsync_rx_chk.sv
module bsync_rx_chk #(
  parameter int DEPTH = 3
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       bitEn,
  input logic                       huntCmd,
  input logic                       rdEn,
  input logic                       inHunt,
  input logic                       xfer,
  input logic [$clog2(DEPTH+1)-1:0] fifoCount
);

  logic [2:0] bitsSince;

  always_ff @(posedge clk) begin
    if (!rstN || inHunt || huntCmd) bitsSince <= '0;
    else if (bitEn)                 bitsSince <= bitsSince + 1'b1;
  end

  // R1: no transfer while hunting
  a_r1_no_xfer_in_hunt: assert property (@(posedge clk) disable iff (!rstN)
    inHunt |-> !xfer);

  // R3: transfers are eight bit times apart after sync
  a_r3_xfer_spacing: assert property (@(posedge clk) disable iff (!rstN)
    xfer |-> (bitsSince == 3'd7));

  // R7: hunt command enters hunt
  a_r7_hunt_cmd: assert property (@(posedge clk) disable iff (!rstN)
    huntCmd |=> inHunt);

  // R8: occupancy never exceeds depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= ($clog2(DEPTH+1))'(DEPTH));

  // R9: push with pop on a full FIFO keeps it full
  a_r9_full_push_pop: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && rdEn && fifoCount == ($clog2(DEPTH+1))'(DEPTH)) |=> fifoCount == $past(fifoCount));

  // R10: a lone pop lowers occupancy by one
  a_r10_pop_decrements: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && fifoCount != '0 && !xfer) |=> fifoCount == $past(fifoCount) - 1'b1);

endmodule

bind bsync_rx bsync_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitEn     (bitEn),
  .huntCmd   (huntCmd),
  .rdEn      (rdEn),
  .inHunt    (inHunt),
  .xfer      (xfer),
  .fifoCount (fifoCount)
);

// File: tb/bsync_rx_tb.sv
module bsync_rx_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic       rxBit = 1'b0;
  logic [7:0] syncChar = 8'h16;
  logic       crcPresetOnes = 1'b1;
  logic       crcEnable = 1'b0;
  logic       huntCmd = 1'b0;
  logic       rdEn = 1'b0;
  logic       inHunt, dataValid, rdCrcErr, rdOverrun;
  logic [7:0] rdData;

  int checks = 0;
  int failures = 0;
  bit monOn = 1'b1;
  bit ovrPend = 1'b0;
  logic [9:0] expQ[$];

  logic [7:0] chars[256];
  bit         incl[256];
  int         nChars = 0;
  logic [15:0] presetNow;

  always #10 clk = ~clk;

  bsync_rx u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .syncChar(syncChar),
    .crcPresetOnes(crcPresetOnes), .crcEnable(crcEnable), .huntCmd(huntCmd),
    .rdEn(rdEn), .inHunt(inHunt), .dataValid(dataValid), .rdData(rdData),
    .rdCrcErr(rdCrcErr), .rdOverrun(rdOverrun)
  );

  function automatic logic [15:0] refByte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [15:0] modelUpTo(input int upto);
    logic [15:0] r;
    r = presetNow;
    for (int j = 0; j <= upto; j++) if (incl[j]) r = refByte(r, chars[j]);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(posedge clk); #2;
    rxBit = b; bitEn = 1'b1;
    @(posedge clk); #2;
    bitEn = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic sendRaw(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  // one post-sync character; enPrev decides inclusion of the previous one
  task automatic sendChar(input logic [7:0] v, input bit enPrev, input bit expDrop,
                          input bit openAtLast);
    bit e;
    #1;
    crcEnable = enPrev;
    if (nChars > 0) incl[nChars-1] = enPrev;
    for (int i = 7; i >= 1; i--) sendBit(v[i]);
    e = (modelUpTo(nChars - 2) != 16'h0);
    if (expDrop) ovrPend = 1'b1;
    else begin
      expQ.push_back({ovrPend, e, v});
      ovrPend = 1'b0;
    end
    chars[nChars] = v;
    incl[nChars] = 1'b0;
    nChars++;
    @(posedge clk); #2;
    rxBit = v[0]; bitEn = 1'b1;
    if (openAtLast) monOn = 1'b1;
    @(posedge clk); #2;
    bitEn = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    logic [9:0] e;
    forever begin
      @(negedge clk);
      if (monOn && dataValid && rstN) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R10 unexpected character", int'(rdData), 0);
        end else begin
          e = expQ.pop_front();
          check(rdData == e[7:0], "R3/R10 data", int'(rdData), int'(e[7:0]));
          check(rdCrcErr == e[8], "R5/R6 crc status", int'(rdCrcErr), int'(e[8]));
          check(rdOverrun == e[9], "R8/R9 overrun", int'(rdOverrun), int'(e[9]));
        end
        rdEn = 1'b1;
      end else begin
        rdEn = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] c;
    presetNow = 16'hFFFF;
    repeat (3) @(posedge clk); #2;
    rstN = 1'b1;
    @(negedge clk);
    check(inHunt == 1'b1, "R1 reset hunt", int'(inHunt), 1);
    check(dataValid == 1'b0, "R10 reset empty", int'(dataValid), 0);

    // R1: garbage does not sync
    sendRaw(8'hA5);
    @(negedge clk);
    check(inHunt == 1'b1, "R1 still hunting", int'(inHunt), 1);
    check(dataValid == 1'b0, "R1 no store in hunt", int'(dataValid), 0);
    sendRaw(8'h16);
    @(negedge clk);
    check(inHunt == 1'b0, "R1 sync found", int'(inHunt), 0);
    check(dataValid == 1'b0, "R2 sync not stored", int'(dataValid), 0);

    // phase A: frame with CRC, preset ones (R6)
    c = 16'hFFFF;
    c = refByte(c, 8'h31); c = refByte(c, 8'h32); c = refByte(c, 8'h33); c = refByte(c, 8'h34);
    sendChar(8'h31, 0, 0, 0);
    sendChar(8'h32, 1, 0, 0);
    sendChar(8'h33, 1, 0, 0);
    sendChar(8'h34, 1, 0, 0);
    sendChar(c[15:8], 1, 0, 0);
    sendChar(c[7:0], 1, 0, 0);
    sendChar(8'h55, 1, 0, 0);
    sendChar(8'hAA, 0, 0, 0);  // R6: status with this one covers the CRC bytes
    check(modelUpTo(nChars - 3) == 16'h0, "R6 bench frame residue", 0, 0);

    // phase B: excluded middle character (R4)
    c = 16'h0000;
    c = refByte(c, 8'h41); c = refByte(c, 8'h42);
    sendChar(8'h41, 0, 0, 0);
    sendChar(8'hEE, 1, 0, 0);     // includes 0x41
    sendChar(8'h42, 0, 0, 0);     // R4 excludes 0xEE
    sendChar(c[15:8], 1, 0, 0);
    sendChar(c[7:0], 1, 0, 0);
    sendChar(8'h5A, 1, 0, 0);
    sendChar(8'hFF, 1, 0, 0);     // includes 0x5A -> non-zero afterwards
    sendChar(8'hFF, 0, 0, 0);
    repeat (20) @(posedge clk);

    // phase C: hunt command resets CRC (R7), preset zeros
    #1;
    crcPresetOnes = 1'b0;
    crcEnable = 1'b1;
    @(posedge clk); #2; huntCmd = 1'b1;
    @(posedge clk); #2; huntCmd = 1'b0;
    @(negedge clk);
    check(inHunt == 1'b1, "R7 hunt entered", int'(inHunt), 1);
    sendRaw(8'hFF);
    @(negedge clk);
    check(dataValid == 1'b0, "R1 no store after hunt", int'(dataValid), 0);
    check(inHunt == 1'b1, "R1 hunting on ones", int'(inHunt), 1);
    sendRaw(8'h16);
    @(negedge clk);
    check(inHunt == 1'b0, "R7 resync", int'(inHunt), 0);
    nChars = 0;
    presetNow = 16'h0000;
    c = 16'h0000;
    c = refByte(c, 8'hC3); c = refByte(c, 8'h3C);
    sendChar(8'hC3, 0, 0, 0);
    sendChar(8'h3C, 1, 0, 0);
    sendChar(c[15:8], 1, 0, 0);
    sendChar(c[7:0], 1, 0, 0);
    sendChar(8'h77, 1, 0, 0);
    sendChar(8'h88, 0, 0, 0);
    repeat (20) @(posedge clk);

    // phase D: overrun (R8)
    monOn = 1'b0;
    sendChar(8'h01, 0, 0, 0);
    sendChar(8'h02, 0, 0, 0);
    sendChar(8'h03, 0, 0, 0);
    sendChar(8'h04, 0, 1, 0);
    sendChar(8'h05, 0, 1, 0);
    @(negedge clk);
    check(dataValid == 1'b1, "R10 full holds data", int'(dataValid), 1);
    monOn = 1'b1;
    repeat (20) @(posedge clk);
    sendChar(8'h06, 0, 0, 0);   // R8 carries overrun
    sendChar(8'h07, 0, 0, 0);
    repeat (20) @(posedge clk);

    // phase E: push and pop in the same cycle on a full FIFO (R9)
    monOn = 1'b0;
    sendChar(8'h11, 0, 0, 0);
    sendChar(8'h12, 0, 0, 0);
    sendChar(8'h13, 0, 0, 0);
    sendChar(8'h14, 0, 0, 1);   // R9 reader released on this boundary
    sendChar(8'h15, 0, 0, 0);
    repeat (40) @(posedge clk);

    @(negedge clk);
    check(expQ.size() == 0, "R10 all characters delivered", expQ.size(), 0);
    check(dataValid == 1'b0, "R10 drained", int'(dataValid), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule